// File: doc/BRIEF.md
# Codec Register Access Controller

This block is a small memory-mapped front end that a host processor uses to start transactions on the register file of an external audio codec. The host writes the codec register number and the outgoing value into storage words. It then writes a command word to launch either a write to the codec or a read from it. The bus is 32 bits wide and takes a byte address. The byte address divided by four picks one of four words: command, codec register number, outgoing data and incoming data.

A command word with the start bit set is accepted at once. On the following clock cycle the block raises one of two interrupt lines for exactly one cycle. The write-request line fires when the direction bit asks for a write to the codec. The read-reply line fires otherwise. The start bit never stays set in the stored command word, so software can read the command word back without retriggering anything. Only whole, aligned 32-bit accesses are accepted. Reads of unmapped words return zero, and writes to unmapped words are dropped.

Top module: `codec_regaccess`

## Requirements
- R1: While reset is high, and after it, every storage word reads as zero and both interrupt lines are low until a command is written.
- R2: A whole, aligned access selects a word by byte address divided by four: 0x00 command, 0x04 codec register number, 0x08 outgoing data, 0x0C incoming data.
- R3: A command write with bit 0 (start) = 1 and bit 1 (direction) = 1 drives irq_wr_req high in the next cycle only, with irq_rd_rep low.
- R4: A command write with bit 0 = 1 and bit 1 = 0 drives irq_rd_rep high in the next cycle only, with irq_wr_req low.
- R5: The stored command word equals the last accepted command write with bit 0 forced to 0 and all other bits kept.
- R6: A command write with bit 0 = 0 updates the stored bits and pulses neither interrupt line.
- R7: The codec register number, outgoing data and incoming data words keep and read back any full 32-bit value written to them.
- R8: An access is accepted only when all four byte enables are 1 and address bits [1:0] are 0. Any other write changes nothing, and any other read returns zero.
- R9: A read of a word offset of 4 or more returns zero, and a write there changes no stored word and pulses no interrupt.
- R10: The two interrupt lines are never high in the same cycle, and each command write produces at most one one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_be | input | 4 | Byte enables; all four must be 1 |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading a mapped word |
| irq_wr_req | output | 1 | One-cycle pulse for a codec write request |
| irq_rd_rep | output | 1 | One-cycle pulse for a codec read request |

## Verification
The assertions assume that reset is held high through the first clock edge. They also assume that bus_wr and bus_rd are never both high, and that every input is a known value at each rising edge. The bench drives every bus input only on falling edges and starts with reset high. It issues one access per cycle and keeps the two strobes apart. Back-to-back command writes are covered, so the pulse checks rest on the one-cycle delay rather than on idle gaps.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;

    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int NUM_SLOTS  = 4;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int GO_BIT     = 0;
    localparam int DIR_BIT    = 1;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_CMD   = 2'd0,
        SLOT_CREG  = 2'd1,
        SLOT_TXD   = 2'd2,
        SLOT_RXD   = 2'd3
    } slot_e;

    typedef struct packed {
        logic  hit;
        slot_e slot;
    } sel_t;

    typedef struct packed {
        logic go;
        logic to_codec;
    } cmd_t;

    function automatic logic word_access(input logic [BE_W-1:0] be,
                                         input logic [1:0] low_addr);
        return (&be) && (low_addr == 2'b00);
    endfunction

    function automatic logic [DATA_W-1:0] strip_go(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        r = v;
        r[GO_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/codec_ctl_decode.sv
module codec_ctl_decode
    import codec_ctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    output sel_t              sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx      = addr[ADDR_W-1:2];
        sel.slot = slot_e'(idx[SLOT_W-1:0]);
        sel.hit  = word_access(be, addr[1:0]) && (idx < IDX_W'(NUM_SLOTS));
    end
endmodule

// File: rtl/codec_ctl_regfile.sv
module codec_ctl_regfile
    import codec_ctl_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  sel_t                               sel,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]   words
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[s] <= '0;
            end else if (we && sel.hit && (sel.slot == slot_e'(s))) begin
                if (s == int'(SLOT_CMD))
                    words[s] <= strip_go(wdata);
                else
                    words[s] <= wdata;
            end
        end
    end

    // R5
    cmd_word_go_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we && sel.hit && sel.slot == SLOT_CMD) |=>
            (words[SLOT_CMD][DATA_W-1:1] == $past(wdata[DATA_W-1:1])) && !words[SLOT_CMD][GO_BIT]);
endmodule

// File: rtl/codec_ctl_irq.sv
module codec_ctl_irq
    import codec_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  cmd_t cmd,
    output logic irq_wr_req,
    output logic irq_rd_rep
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_wr_req <= 1'b0;
            irq_rd_rep <= 1'b0;
        end else begin
            irq_wr_req <= fire && cmd.go &&  cmd.to_codec;
            irq_rd_rep <= fire && cmd.go && !cmd.to_codec;
        end
    end

    // R10
    irq_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(irq_wr_req && irq_rd_rep));

    // R6
    no_pulse_without_go_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !cmd.go) |=> !irq_wr_req && !irq_rd_rep);
endmodule

// File: rtl/codec_regaccess.sv
module codec_regaccess
    import codec_ctl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_wr_req,
    output logic              irq_rd_rep
);
    sel_t                             sel;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] words;
    logic                             cmd_write;
    cmd_t                             cmd;

    codec_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .be   (bus_be),
        .sel  (sel)
    );

    codec_ctl_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .words (words)
    );

    always_comb begin
        cmd_write    = bus_wr && sel.hit && (sel.slot == SLOT_CMD);
        cmd.go       = bus_wdata[GO_BIT];
        cmd.to_codec = bus_wdata[DIR_BIT];
    end

    codec_ctl_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .fire       (cmd_write),
        .cmd        (cmd),
        .irq_wr_req (irq_wr_req),
        .irq_rd_rep (irq_rd_rep)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && sel.hit)
            bus_rdata = words[sel.slot];
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !irq_wr_req && !irq_rd_rep);

    // R3
    wr_req_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_wr_req |-> $past(bus_wr && (&bus_be) && bus_addr == '0 && bus_wdata[1:0] == 2'b11));

    // R4
    rd_rep_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_rd_rep |-> $past(bus_wr && (&bus_be) && bus_addr == '0 && bus_wdata[1:0] == 2'b01));

    // R8
    partial_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !(&bus_be)) |-> bus_rdata == '0);

    // R9
    unmapped_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[ADDR_W-1:2] >= (ADDR_W-2)'(NUM_SLOTS)) |=> $stable(words));
endmodule

// File: tb/tb_codec_regaccess.sv
module tb_codec_regaccess;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_wr_req, irq_rd_rep;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    codec_regaccess dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_wr_req(irq_wr_req), .irq_rd_rep(irq_rd_rep)
    );

    // {addr, be, wdata, expected readback, exp wr pulse, exp rd pulse}
    localparam int NV = 9;
    localparam logic [75:0] VEC [NV] = '{
        {6'h04, 4'hF, 32'h0000_00A5, 32'h0000_00A5, 1'b0, 1'b0},
        {6'h08, 4'hF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 1'b0},
        {6'h0C, 4'hF, 32'h1234_5678, 32'h1234_5678, 1'b0, 1'b0},
        {6'h00, 4'hF, 32'h0000_0003, 32'h0000_0002, 1'b1, 1'b0},
        {6'h00, 4'hF, 32'hF000_0001, 32'hF000_0000, 1'b0, 1'b1},
        {6'h00, 4'hF, 32'h0000_0002, 32'h0000_0002, 1'b0, 1'b0},
        {6'h00, 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b1, 1'b0},
        {6'h04, 4'h3, 32'h1111_1111, 32'h0000_00A5, 1'b0, 1'b0},
        {6'h10, 4'hF, 32'h5555_5555, 32'h0000_0000, 1'b0, 1'b0}
    };
    localparam string VTAG [NV] = '{"R7", "R7", "R2", "R3", "R4", "R6", "R5", "R8", "R9"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [3:0] be, output logic [31:0] d);
        bus_addr = a; bus_be = be; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        rst = 1'b0;
        for (int s = 0; s < 4; s++) begin
            rd(6'(s * 4), 4'hF, v);
            check("R1 reset word", v, 32'h0);
        end
        check("R1 irq idle", {30'b0, irq_wr_req, irq_rd_rep}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][75:70], VEC[i][69:66], VEC[i][65:34]);
            check({VTAG[i], " pulse"}, {30'b0, irq_wr_req, irq_rd_rep}, {30'b0, VEC[i][1:0]});
            rd(VEC[i][75:70], 4'hF, v);
            check({VTAG[i], " readback"}, v, VEC[i][33:2]);
            check("R10 pulse ends", {30'b0, irq_wr_req, irq_rd_rep}, 32'h0);
        end

        // R8: misaligned write ignored, partial read gives zero
        wr(6'h05, 4'hF, 32'hCAFE_0000);
        rd(6'h04, 4'hF, v);
        check("R8 misaligned write", v, 32'h0000_00A5);
        rd(6'h08, 4'h1, v);
        check("R8 partial read", v, 32'h0);
        rd(6'h09, 4'hF, v);
        check("R8 misaligned read", v, 32'h0);

        // R9: unmapped write leaves every word alone, no pulse
        wr(6'h3C, 4'hF, 32'h0000_0003);
        check("R9 no pulse", {30'b0, irq_wr_req, irq_rd_rep}, 32'h0);
        rd(6'h0C, 4'hF, v);
        check("R9 rx word kept", v, 32'h1234_5678);
        rd(6'h3C, 4'hF, v);
        check("R9 unmapped read", v, 32'h0);

        // R10: back-to-back commands give one pulse each, never both lines
        @(negedge clk);
        bus_addr = 6'h00; bus_be = 4'hF; bus_wr = 1'b1; bus_wdata = 32'h3;
        @(negedge clk);
        check("R10 first pulse", {30'b0, irq_wr_req, irq_rd_rep}, 32'h2);
        bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10 second pulse", {30'b0, irq_wr_req, irq_rd_rep}, 32'h1);
        @(negedge clk);
        check("R10 quiet after", {30'b0, irq_wr_req, irq_rd_rep}, 32'h0);

        // R1: reset mid-run clears the words
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(6'h08, 4'hF, v);
        check("R1 rerset clears", v, 32'h0);
        rd(6'h00, 4'hF, v);
        check("R1 cmd cleared", v, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule